// File: doc/BRIEF.md
# Masked Interrupt Request Aggregator

This block gathers up to eight interrupt sources into one pending register and drives a single interrupt line toward a system-level interrupt controller. Sources set pending bits by raising a post strobe together with a bit vector. They remove bits by raising a clear strobe together with a bit vector. Software programs a primary enable mask through a byte-wide register port; a mask bit of 1 enables the matching source. A secondary mask register is also reachable through the port. It holds and returns whatever is written to it, but it plays no part in the interrupt decision.

The output is not a continuous function of pending and mask. It is re-evaluated only when a post, a clear or a primary-mask write happens. A sticky interrupting flag makes sure that a run of posts produces only one assert pulse. A clear whose result leaves no enabled source pending drops the flag and emits a deassert pulse. A mask write can raise the line but never lowers it. The flag is also driven out as a level.

Top module: `irq_gather`

## Requirements
- R1: While reset is active (rst_n low at a clock edge), the pending register, both masks and the interrupting flag return to zero, and neither pulse output is high on the following cycle.
- R2: A post ORs post_vec into the pending register. The pending register reads back at reg_addr 2.
- R3: A clear removes every bit set in clr_vec from the pending register.
- R4: When a post leaves (pending AND primary mask) nonzero while the flag is clear, the flag is set and irq_set_pulse is high for exactly the one cycle after that edge.
- R5: A post or mask write while the flag is already set produces no further irq_set_pulse.
- R6: A clear that leaves (pending AND primary mask) zero clears the flag and raises irq_clr_pulse for one cycle. A clear that leaves any enabled source pending changes neither the flag nor the pulses.
- R7: Writing the primary mask (reg_addr 0) stores the new value and performs the same assert check as a post, using the new mask. A mask bit of 1 enables its source.
- R8: A primary mask write never clears the flag and never raises irq_clr_pulse.
- R9: The secondary mask (reg_addr 1) stores and reads back the written byte and never affects irq_level or either pulse. Writes to reg_addr 2 or 3 are ignored, and reg_addr 3 reads as zero.
- R10: When post and clear fall in the same cycle, the clear is applied after the post. The assert check sees the posted value, and the deassert check sees the result after the clear. Both pulses may then be high together, and irq_level follows the final flag.
- R11: irq_level equals the interrupting flag. It rises only together with irq_set_pulse and falls only together with irq_clr_pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| post_en | input | 1 | Post strobe |
| post_vec | input | 8 | Sources to set pending |
| clr_en | input | 1 | Clear strobe |
| clr_vec | input | 8 | Sources to clear |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 primary mask, 1 secondary mask, 2 pending (read-only), 3 unused |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for the selected register (combinational) |
| irq_level | output | 1 | Interrupting flag |
| irq_set_pulse | output | 1 | One-cycle assert pulse to the downstream controller |
| irq_clr_pulse | output | 1 | One-cycle deassert pulse to the downstream controller |

## Verification
Three events can land in one cycle: a post, a clear and a primary-mask write. The interesting overlap is a post and a clear in the same cycle. The sweeps drive both strobes at once with overlapping and disjoint vectors, and also combine them with a mask write. Each cycle is judged against a bench model that first applies the mask and the post and runs the assert check, then applies the clear and runs the deassert check. The model predicts both pulses, the final level and the pending value read back afterwards.

// File: rtl/irqg_pkg.sv
// Package: shared register-select encoding for the interrupt aggregator.
// Assumes a 2-bit register address on the byte-wide register port.
package irqg_pkg;
    typedef enum logic [1:0] {
        REG_MASK_PRI = 2'd0,
        REG_MASK_SEC = 2'd1,
        REG_PEND     = 2'd2,
        REG_NONE     = 2'd3
    } irqg_reg_e;
endpackage

// File: rtl/irqg_mask_regs.sv
// Module: holds the primary and secondary mask registers.
// Also provides the mask value that takes effect in the current cycle, so that
// the evaluator can judge a mask write against the new mask.
// Assumes one write per cycle; writes to other addresses are ignored here.
module irqg_mask_regs
    import irqg_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  irqg_reg_e        wr_addr,
    input  logic [N_SRC-1:0] wr_data,
    output logic [N_SRC-1:0] mask_pri_q,
    output logic [N_SRC-1:0] mask_sec_q,
    output logic [N_SRC-1:0] mask_eff,
    output logic             pri_wr
);
    logic sec_wr;

    // Decode which mask register this cycle's write targets.
    always_comb begin
        pri_wr = wr_en && (wr_addr == REG_MASK_PRI);
        sec_wr = wr_en && (wr_addr == REG_MASK_SEC);
    end

    // Mask seen by this cycle's evaluation: the new value on a write.
    always_comb begin
        mask_eff = pri_wr ? wr_data : mask_pri_q;
    end

    // Primary mask storage.
    always_ff @(posedge clk) begin
        if (!rst_n)      mask_pri_q <= '0;
        else if (pri_wr) mask_pri_q <= wr_data;
    end

    // Secondary mask storage; it has no path into the interrupt logic.
    always_ff @(posedge clk) begin
        if (!rst_n)      mask_sec_q <= '0;
        else if (sec_wr) mask_sec_q <= wr_data;
    end
endmodule

// File: rtl/irqg_pending.sv
// Module: pending register with post-then-clear ordering per bit.
// Exposes the value after the post (pend_mid) and after the clear (pend_next).
// Assumes the strobes qualify their vectors; vectors are ignored otherwise.
module irqg_pending #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             post_en,
    input  logic [N_SRC-1:0] post_vec,
    input  logic             clr_en,
    input  logic [N_SRC-1:0] clr_vec,
    output logic [N_SRC-1:0] pend_q,
    output logic [N_SRC-1:0] pend_mid,
    output logic [N_SRC-1:0] pend_next
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        // Per-source next state: post sets first, then clear removes.
        always_comb begin
            pend_mid[i]  = pend_q[i] | (post_en & post_vec[i]);
            pend_next[i] = pend_mid[i] & ~(clr_en & clr_vec[i]);
        end
    end

    // Pending register update.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_next;
    end
endmodule

// File: rtl/irqg_eval.sv
// Module: event-driven assert/deassert evaluator with a sticky flag.
// The assert check runs on a post or primary mask write; the deassert check
// runs on a clear, after the assert check. Pulses are registered one-cycle.
// Assumes pend_mid/pend_next come from the same cycle's pending logic.
module irqg_eval #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             post_en,
    input  logic             pri_wr,
    input  logic             clr_en,
    input  logic [N_SRC-1:0] mask_eff,
    input  logic [N_SRC-1:0] pend_mid,
    input  logic [N_SRC-1:0] pend_next,
    output logic             flag_q,
    output logic             set_pulse_q,
    output logic             clr_pulse_q
);
    logic set_d;
    logic drop_d;
    logic flag_d;

    // Assert and deassert decisions for this cycle, in post-then-clear order.
    always_comb begin
        set_d  = (post_en | pri_wr) && (|(pend_mid & mask_eff)) && !flag_q;
        drop_d = clr_en && !(|(pend_next & mask_eff));
        flag_d = drop_d ? 1'b0 : (flag_q | set_d);
    end

    // Flag and pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q      <= 1'b0;
            set_pulse_q <= 1'b0;
            clr_pulse_q <= 1'b0;
        end else begin
            flag_q      <= flag_d;
            set_pulse_q <= set_d;
            clr_pulse_q <= drop_d;
        end
    end
endmodule

// File: rtl/irq_gather.sv
// Module: top of the masked interrupt request aggregator.
// Wires the mask registers, pending register and evaluator together, and
// muxes register readback. Assumes synchronous active-low reset.
module irq_gather
    import irqg_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             post_en,
    input  logic [N_SRC-1:0] post_vec,
    input  logic             clr_en,
    input  logic [N_SRC-1:0] clr_vec,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [N_SRC-1:0] reg_wdata,
    output logic [N_SRC-1:0] reg_rdata,
    output logic             irq_level,
    output logic             irq_set_pulse,
    output logic             irq_clr_pulse
);
    irqg_reg_e        addr_e;
    logic [N_SRC-1:0] mask_pri_q;
    logic [N_SRC-1:0] mask_sec_q;
    logic [N_SRC-1:0] mask_eff;
    logic             pri_wr;
    logic [N_SRC-1:0] pend_q;
    logic [N_SRC-1:0] pend_mid;
    logic [N_SRC-1:0] pend_next;
    logic             flag_q;
    logic             set_pulse_q;
    logic             clr_pulse_q;

    // Typed view of the register address.
    always_comb addr_e = irqg_reg_e'(reg_addr);

    irqg_mask_regs #(.N_SRC(N_SRC)) u_masks (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .wr_addr    (addr_e),
        .wr_data    (reg_wdata),
        .mask_pri_q (mask_pri_q),
        .mask_sec_q (mask_sec_q),
        .mask_eff   (mask_eff),
        .pri_wr     (pri_wr)
    );

    irqg_pending #(.N_SRC(N_SRC)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .post_en   (post_en),
        .post_vec  (post_vec),
        .clr_en    (clr_en),
        .clr_vec   (clr_vec),
        .pend_q    (pend_q),
        .pend_mid  (pend_mid),
        .pend_next (pend_next)
    );

    irqg_eval #(.N_SRC(N_SRC)) u_eval (
        .clk         (clk),
        .rst_n       (rst_n),
        .post_en     (post_en),
        .pri_wr      (pri_wr),
        .clr_en      (clr_en),
        .mask_eff    (mask_eff),
        .pend_mid    (pend_mid),
        .pend_next   (pend_next),
        .flag_q      (flag_q),
        .set_pulse_q (set_pulse_q),
        .clr_pulse_q (clr_pulse_q)
    );

    // Register readback multiplexer.
    always_comb begin
        case (addr_e)
            REG_MASK_PRI: reg_rdata = mask_pri_q;
            REG_MASK_SEC: reg_rdata = mask_sec_q;
            REG_PEND:     reg_rdata = pend_q;
            default:      reg_rdata = '0;
        endcase
    end

    // Output drive.
    always_comb begin
        irq_level     = flag_q;
        irq_set_pulse = set_pulse_q;
        irq_clr_pulse = clr_pulse_q;
    end
endmodule

// File: rtl/irq_gather_chk.sv
// Module: assertion checker for irq_gather, attached with bind.
// Observes ports plus the pending register; drives nothing.
module irq_gather_chk #(
    parameter int N_SRC = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             post_en,
    input logic [N_SRC-1:0] post_vec,
    input logic             clr_en,
    input logic [N_SRC-1:0] clr_vec,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic [N_SRC-1:0] reg_wdata,
    input logic             irq_level,
    input logic             irq_set_pulse,
    input logic             irq_clr_pulse,
    input logic [N_SRC-1:0] pend_q
);
    p_post_sets_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        post_en && !clr_en |=> ((pend_q & $past(post_vec)) == $past(post_vec)));

    p_clear_drops_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((pend_q & $past(clr_vec)) == '0));

    p_no_dup_assert_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_level && !clr_en |=> !irq_set_pulse);

    p_mask_wr_enables_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == 2'd0 && !post_en && !clr_en && !irq_level
        && ((pend_q & reg_wdata) != '0) |=> irq_set_pulse && irq_level);

    p_mask_wr_no_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && !clr_en |=> !irq_clr_pulse);

    p_sec_no_effect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr != 2'd0 && !post_en && !clr_en
        |=> !irq_set_pulse && !irq_clr_pulse && $stable(irq_level));

    p_post_then_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        post_en && clr_en |=> ((pend_q & $past(post_vec & ~clr_vec))
                               == $past(post_vec & ~clr_vec)));

    p_level_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_level) |-> irq_set_pulse);

    p_level_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_level) |-> irq_clr_pulse);
endmodule

bind irq_gather irq_gather_chk #(.N_SRC(N_SRC)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .post_en       (post_en),
    .post_vec      (post_vec),
    .clr_en        (clr_en),
    .clr_vec       (clr_vec),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .irq_level     (irq_level),
    .irq_set_pulse (irq_set_pulse),
    .irq_clr_pulse (irq_clr_pulse),
    .pend_q        (pend_q)
);

// File: tb/irq_gather_tb.sv
module irq_gather_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       post_en = 1'b0;
    logic [7:0] post_vec = '0;
    logic       clr_en = 1'b0;
    logic [7:0] clr_vec = '0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_level;
    logic       irq_set_pulse;
    logic       irq_clr_pulse;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Bench model state
    logic [7:0] m_pend = '0;
    logic [7:0] m_pri = '0;
    logic [7:0] m_sec = '0;
    logic       m_flag = 1'b0;
    logic [31:0] lfsr = 32'hACE1_2345;

    always #2 clk = ~clk;

    irq_gather u_dut (
        .clk(clk), .rst_n(rst_n),
        .post_en(post_en), .post_vec(post_vec),
        .clr_en(clr_en), .clr_vec(clr_vec),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_level(irq_level),
        .irq_set_pulse(irq_set_pulse), .irq_clr_pulse(irq_clr_pulse)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // One cycle of stimulus; checks pulses and level after the edge.
    task automatic step(input logic p, input logic [7:0] pv, input logic c,
                        input logic [7:0] cv, input logic w, input logic [1:0] a,
                        input logic [7:0] wd, input string tag);
        logic [7:0] pri_n, sec_n, mid, fin;
        logic setp, clrp, f1, fl;
        pri_n = (w && a == 2'd0) ? wd : m_pri;
        sec_n = (w && a == 2'd1) ? wd : m_sec;
        mid   = m_pend | (p ? pv : 8'h00);
        setp  = (p || (w && a == 2'd0)) && ((mid & pri_n) != 0) && !m_flag;
        f1    = m_flag | setp;
        fin   = mid & ~(c ? cv : 8'h00);
        clrp  = c && ((fin & pri_n) == 0);
        fl    = clrp ? 1'b0 : f1;
        @(negedge clk);
        post_en = p; post_vec = pv; clr_en = c; clr_vec = cv;
        reg_wr = w; reg_addr = a; reg_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        post_en = 0; clr_en = 0; reg_wr = 0;
        chk({tag, " set_pulse"}, 32'(irq_set_pulse), 32'(setp));
        chk({tag, " clr_pulse R11"}, 32'(irq_clr_pulse), 32'(clrp));
        chk({tag, " level R11"}, 32'(irq_level), 32'(fl));
        m_pend = fin; m_pri = pri_n; m_sec = sec_n; m_flag = fl;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, 32'(reg_rdata), 32'(exp));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        m_pend = '0; m_pri = '0; m_sec = '0; m_flag = 0;
    endtask

    task automatic reset_checks(input string tag);
        chk({tag, " level"}, 32'(irq_level), 0);
        chk({tag, " set"}, 32'(irq_set_pulse), 0);
        chk({tag, " clr"}, 32'(irq_clr_pulse), 0);
        rd(2'd0, 8'h00, {tag, " pri"});
        rd(2'd1, 8'h00, {tag, " sec"});
        rd(2'd2, 8'h00, {tag, " pend"});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        reset_checks("R1 reset");

        // R4/R5/R6/R8 directed: enable all, post, mask to zero, clear
        step(0, 0, 0, 0, 1, 2'd0, 8'hFF, "R7 mask all");
        step(1, 8'h01, 0, 0, 0, 0, 0, "R4 first post");
        step(1, 8'h02, 0, 0, 0, 0, 0, "R5 dup post");
        rd(2'd2, 8'h03, "R2 pend readback");
        step(0, 0, 1, 8'h01, 0, 0, 0, "R6 partial clear");
        step(0, 0, 0, 0, 1, 2'd0, 8'h00, "R8 mask zero");
        chk("R8 level held", 32'(irq_level), 1);
        step(0, 0, 1, 8'h02, 0, 0, 0, "R6 full clear");
        rd(2'd2, 8'h00, "R3 pend empty");

        // R9: secondary mask, unused addresses
        step(1, 8'h10, 0, 0, 0, 0, 0, "R9 post masked");
        step(0, 0, 0, 0, 1, 2'd1, 8'hFF, "R9 sec write");
        rd(2'd1, 8'hFF, "R9 sec readback");
        step(0, 0, 0, 0, 1, 2'd2, 8'h00, "R9 pend write ignored");
        rd(2'd2, 8'h10, "R9 pend kept");
        step(0, 0, 0, 0, 1, 2'd3, 8'h5A, "R9 addr3 write");
        rd(2'd3, 8'h00, "R9 addr3 zero");
        rd(2'd0, 8'h00, "R9 pri untouched");
        step(0, 0, 0, 0, 1, 2'd0, 8'h10, "R7 mask write asserts");

        // R10: same-cycle post and clear, overlapping
        step(0, 0, 1, 8'hFF, 0, 0, 0, "R10 prep clear");
        step(1, 8'h06, 1, 8'h06, 0, 0, 0, "R10 overlap");
        rd(2'd2, 8'h00, "R10 pend after overlap");
        step(1, 8'h30, 1, 8'h20, 1, 2'd0, 8'h20, "R10 with mask write");
        rd(2'd2, 8'h10, "R10 pend disjoint");

        // Mid-run reset
        do_reset();
        reset_checks("R1 rerun");

        // Exhaustive mask sweep with post patterns
        for (int m = 0; m < 256; m++) begin
            for (int k = 0; k < 8; k++) begin
                logic [7:0] pv;
                pv = 8'((k * 73 + m * 5 + 1) ^ (1 << k));
                step(0, 0, 1, 8'hFF, 0, 0, 0, "R6 sweep clear");
                step(0, 0, 0, 0, 1, 2'd0, 8'(m), "R7 sweep mask");
                step(1, pv, 0, 0, 0, 0, 0, "R4 sweep post");
                step(1, pv, 1, 8'(1 << k), 0, 0, 0, "R10 sweep post+clear");
            end
        end
        rd(2'd0, 8'hFF, "R7 final mask");

        // Pseudo-random mixed traffic
        for (int n = 0; n < 4000; n++) begin
            logic [1:0] a;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = lfsr[9:8];
            step(lfsr[0], lfsr[15:8], lfsr[1] & lfsr[2], lfsr[23:16] | lfsr[31:24],
                 lfsr[3] & lfsr[4], a, lfsr[31:24], "R10 random");
            if (n % 16 == 0) rd(2'd2, m_pend, "R2 random pend");
            if (n % 16 == 8) rd(2'd1, m_sec, "R9 random sec");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule